// File: doc/BRIEF.md
# Keyboard Memory Monitor Panel

This block turns a stream of keyboard scan codes into a small hardware monitor for a processor system. In entry mode the processor is held in reset and the user examines and deposits memory one byte at a time: a four-digit address field and a two-digit data field are shown on a six-digit hex display, hex keys edit the data byte one nibble at a time, and three single keys move the address and commit bytes. In run mode the processor is released, the display follows the processor's own address and data buses, and two keys give single-step and free-run control.

Scan code bytes arrive with a one-cycle valid strobe from an external keyboard receiver. The block drives a memory port with separate read and write strobes. Read data is expected one clock after the read strobe. Digit values and decimal-point enables go to an external seven-segment driver. No microcontroller is involved; the monitor is a few small state machines.

Top module: `kbd_mem_panel`

## Requirements
- R1: After reset the block is in entry mode with address 0x0000, data 0x00, `cpu_reset` high, `cpu_clk_en` low, no memory strobe, and all six decimal points lit.
- R2: Escape (scan code 0x76) toggles the mode. In entry mode `cpu_reset` is high and `disp_dp` is 6'b111111. In run mode `cpu_reset` is low and `disp_dp` is 0.
- R3: `disp_hex` is {address, data}, with the address in bits 23:8 and the data byte in bits 7:0. In entry mode these are the panel's own fields. In run mode they are {`cpu_addr`, `cpu_data`}.
- R4: In entry mode Space (0x29) sets the address to 0x0000, leaves the data field unchanged and issues no memory strobe.
- R5: In entry mode Enter (0x5A) works as follows, where k is the clock edge that accepts the key byte. `mem_wr` is high for one cycle, sampled at edge k+2, with `mem_addr` equal to the old address and `mem_wdata` equal to the data field. Next, `mem_rd` is high for one cycle at the old address plus one. The address field then becomes old plus one, and the data field becomes the byte read back. The next hex key edits the high nibble.
- R6: In entry mode Backspace (0x66) decrements the address, reads that location once and shows the byte read. It issues no write.
- R7: In entry mode the hex keys edit the data field. The codes are 0x45,0x16,0x1E,0x26,0x25,0x2E,0x36,0x3D,0x3E,0x46 for 0..9 and 0x1C,0x32,0x21,0x23,0x24,0x2B for a..f. Successive hex keys alternate between replacing bits 7:4 and bits 3:0, starting with bits 7:4 after reset or Enter.
- R8: The address changes only through Space, Enter and Backspace. Hex keys, S and R leave it unchanged.
- R9: The address wraps modulo 65536: Backspace at 0x0000 gives 0xFFFF, and Enter at 0xFFFF gives 0x0000.
- R10: `cpu_clk_en` is always low in entry mode. In run mode with the processor stopped, S (0x1B) gives exactly one cycle of `cpu_clk_en` and R (0x2D) starts continuous enable. While running, S has no effect and a second R stops the processor. Leaving run mode stops the processor.
- R11: A byte that follows the break prefix 0xF0 is discarded. The extended prefix 0xE0 is dropped and the byte after it is decoded normally. Every repeated make code counts as a new keypress.
- R12: A key that arrives while an Enter or Backspace memory sequence is still in progress is ignored. Hex, Space, Enter and Backspace are ignored in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_code | input | 8 | Keyboard scan code byte |
| kb_valid | input | 1 | One-cycle strobe: `kb_code` holds a new byte |
| cpu_addr | input | 16 | Processor address bus, shown in run mode |
| cpu_data | input | 8 | Processor data bus, shown in run mode |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_rd` |
| mem_addr | output | 16 | Memory address for panel accesses |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| cpu_reset | output | 1 | Processor reset, high in entry mode |
| cpu_clk_en | output | 1 | Processor clock enable (step or run) |
| disp_hex | output | 24 | Six hex digit values, most significant digit in bits 23:20 |
| disp_dp | output | 6 | Decimal-point enables, one per digit |

## Verification
On every cycle the assertions check several properties. A write is always followed by a read at the next address, and the two strobes never overlap. Backspace, Space and ignored keys move the address exactly as required. A break prefix suppresses the following event. `cpu_clk_en` stays low in entry mode, and each mode key flips the mode. Only the bench's scenarios can show end-to-end results: that the byte read back reaches the display, the order of nibble entry, what survives a round trip through a deposit sweep, and the exact counts of step and run enables.

// File: rtl/kbp_pkg.sv
package kbp_pkg;

  localparam logic [7:0] SC_BREAK  = 8'hF0;
  localparam logic [7:0] SC_EXTEND = 8'hE0;
  localparam logic [7:0] SC_SPACE  = 8'h29;
  localparam logic [7:0] SC_ENTER  = 8'h5A;
  localparam logic [7:0] SC_BKSP   = 8'h66;
  localparam logic [7:0] SC_ESC    = 8'h76;
  localparam logic [7:0] SC_KEY_S  = 8'h1B;
  localparam logic [7:0] SC_KEY_R  = 8'h2D;

  typedef enum logic [2:0] {
    KEY_NONE, KEY_HEX, KEY_CLEAR, KEY_DEPOSIT,
    KEY_BACK, KEY_MODE, KEY_STEP, KEY_RUN
  } key_kind_e;

  typedef struct packed {
    key_kind_e  kind;
    logic [3:0] nib;
  } key_t;

  // Scan code set 2 make code to key event
  function automatic key_t decode_scan(input logic [7:0] c);
    key_t r;
    r.kind = KEY_HEX;
    r.nib  = 4'h0;
    case (c)
      8'h45: r.nib = 4'h0;
      8'h16: r.nib = 4'h1;
      8'h1E: r.nib = 4'h2;
      8'h26: r.nib = 4'h3;
      8'h25: r.nib = 4'h4;
      8'h2E: r.nib = 4'h5;
      8'h36: r.nib = 4'h6;
      8'h3D: r.nib = 4'h7;
      8'h3E: r.nib = 4'h8;
      8'h46: r.nib = 4'h9;
      8'h1C: r.nib = 4'hA;
      8'h32: r.nib = 4'hB;
      8'h21: r.nib = 4'hC;
      8'h23: r.nib = 4'hD;
      8'h24: r.nib = 4'hE;
      8'h2B: r.nib = 4'hF;
      SC_SPACE: r.kind = KEY_CLEAR;
      SC_ENTER: r.kind = KEY_DEPOSIT;
      SC_BKSP:  r.kind = KEY_BACK;
      SC_ESC:   r.kind = KEY_MODE;
      SC_KEY_S: r.kind = KEY_STEP;
      SC_KEY_R: r.kind = KEY_RUN;
      default:  r.kind = KEY_NONE;
    endcase
    return r;
  endfunction

  // Replace one nibble of a data byte
  function automatic logic [7:0] put_nib(input logic [7:0] d, input logic [3:0] n,
                                         input logic hi);
    return hi ? {n, d[3:0]} : {d[7:4], n};
  endfunction

endpackage

// File: rtl/kbp_keydec.sv
module kbp_keydec
  import kbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] kb_code,
  input  logic       kb_valid,
  output logic       evt_stb,
  output key_t       evt
);

  logic brk_pend;
  key_t dec;
  logic is_brk, is_ext, emit;

  assign dec    = decode_scan(kb_code);
  assign is_brk = kb_valid && (kb_code == SC_BREAK);
  assign is_ext = kb_valid && (kb_code == SC_EXTEND);
  assign emit   = kb_valid && !is_brk && !is_ext && !brk_pend && (dec.kind != KEY_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_pend <= 1'b0;
      evt_stb  <= 1'b0;
      evt      <= '0;
    end else begin
      evt_stb <= emit;
      if (emit) evt <= dec;
      if (is_brk)                brk_pend <= 1'b1;
      else if (kb_valid && !is_ext) brk_pend <= 1'b0;
    end
  end

  AST_BREAK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pend && kb_valid |=> !evt_stb); // R11

endmodule

// File: rtl/kbp_entry.sv
module kbp_entry
  import kbp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_stb,
  input  key_t              evt,
  input  logic              entry_mode,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT, ST_LOAD} seq_e;
  seq_e st;
  logic hi_sel;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a,
                                                  input logic up);
    return up ? a + ADDR_W'(1) : a - ADDR_W'(1);
  endfunction

  logic accept, do_hex, do_clear, do_deposit, do_back;
  assign busy       = (st != ST_IDLE);
  assign accept     = evt_stb && entry_mode && !busy;
  assign do_hex     = accept && (evt.kind == KEY_HEX);
  assign do_clear   = accept && (evt.kind == KEY_CLEAR);
  assign do_deposit = accept && (evt.kind == KEY_DEPOSIT);
  assign do_back    = accept && (evt.kind == KEY_BACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr      <= '0;
      data      <= '0;
      hi_sel    <= 1'b1;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (do_hex) begin
            data   <= put_nib(data, evt.nib, hi_sel);
            hi_sel <= ~hi_sel;
          end
          if (do_clear) addr <= '0;
          if (do_deposit) begin
            mem_wr    <= 1'b1;
            mem_addr  <= addr;
            mem_wdata <= data;
            addr      <= addr_step(addr, 1'b1);
            hi_sel    <= 1'b1;
            st        <= ST_READ;
          end
          if (do_back) begin
            addr     <= addr_step(addr, 1'b0);
            mem_addr <= addr_step(addr, 1'b0);
            mem_rd   <= 1'b1;
            st       <= ST_WAIT;
          end
        end
        ST_READ: begin
          mem_wr   <= 1'b0;
          mem_rd   <= 1'b1;
          mem_addr <= addr;
          st       <= ST_WAIT;
        end
        ST_WAIT: begin
          mem_rd <= 1'b0;
          st     <= ST_LOAD;
        end
        default: begin
          data <= mem_rdata;
          st   <= ST_IDLE;
        end
      endcase
    end
  end

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R5
  AST_WR_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> mem_rd && (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R5
  AST_BACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    do_back |=> mem_rd && (addr == $past(addr) - ADDR_W'(1))); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (addr == '0) && !mem_rd && !mem_wr); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb && !(do_clear || do_deposit || do_back) |=> $stable(addr)); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb && busy |=> $stable(addr)); // R12

endmodule

// File: rtl/kbp_runctl.sv
module kbp_runctl
  import kbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_stb,
  input  key_t evt,
  input  logic busy,
  output logic entry_mode,
  output logic cpu_reset,
  output logic cpu_clk_en
);

  logic running, step_q;
  logic do_mode, do_step, do_run;

  assign do_mode = evt_stb && !busy && (evt.kind == KEY_MODE);
  assign do_step = evt_stb && !entry_mode && !running && (evt.kind == KEY_STEP);
  assign do_run  = evt_stb && !entry_mode && (evt.kind == KEY_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_mode <= 1'b1;
      running    <= 1'b0;
      step_q     <= 1'b0;
    end else begin
      step_q <= do_step;
      if (do_mode) begin
        entry_mode <= ~entry_mode;
        running    <= 1'b0;
      end else if (do_run) begin
        running <= ~running;
      end
    end
  end

  assign cpu_reset  = entry_mode;
  assign cpu_clk_en = !entry_mode && (running || step_q);

  AST_MODE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    do_mode |=> entry_mode != $past(entry_mode)); // R2
  AST_NO_CLK_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> !cpu_clk_en); // R10

endmodule

// File: rtl/kbd_mem_panel.sv
module kbd_mem_panel
  import kbp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                kb_code,
  input  logic                      kb_valid,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [7:0]                cpu_data,
  input  logic [7:0]                mem_rdata,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [7:0]                mem_wdata,
  output logic                      cpu_reset,
  output logic                      cpu_clk_en,
  output logic [ADDR_W+8-1:0]       disp_hex,
  output logic [(ADDR_W+8)/4-1:0]   disp_dp
);

  localparam int NDIG = (ADDR_W + 8) / 4;

  logic              evt_stb, busy, entry_mode;
  key_t              evt;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        data;
  logic [NDIG*4-1:0] panel_val, bus_val;

  kbp_keydec u_keydec (
    .clk(clk), .rst_n(rst_n), .kb_code(kb_code), .kb_valid(kb_valid),
    .evt_stb(evt_stb), .evt(evt)
  );

  kbp_entry #(.ADDR_W(ADDR_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .evt(evt),
    .entry_mode(entry_mode), .mem_rdata(mem_rdata),
    .addr(addr), .data(data), .busy(busy),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  kbp_runctl u_runctl (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .evt(evt), .busy(busy),
    .entry_mode(entry_mode), .cpu_reset(cpu_reset), .cpu_clk_en(cpu_clk_en)
  );

  assign panel_val = {addr, data};
  assign bus_val   = {cpu_addr, cpu_data};

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    assign disp_hex[g*4 +: 4] = entry_mode ? panel_val[g*4 +: 4] : bus_val[g*4 +: 4];
    assign disp_dp[g]         = entry_mode;
  end

  AST_DP_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> (disp_dp == {NDIG{1'b1}})); // R2

endmodule

// File: tb/kbd_mem_panel_bench.sv
`timescale 1ns/1ps
module kbd_mem_panel_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  kb_code = '0;
  logic        kb_valid = 1'b0;
  logic [15:0] cpu_addr = 16'hBEEF;
  logic [7:0]  cpu_data = 8'h42;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, cpu_reset, cpu_clk_en;
  logic [7:0]  mem_wdata;
  logic [23:0] disp_hex;
  logic [5:0]  disp_dp;

  kbd_mem_panel u_kbd_mem_panel (.*);

  localparam logic [7:0] HEXC [16] = '{8'h45,8'h16,8'h1E,8'h26,8'h25,8'h2E,8'h36,8'h3D,
                                       8'h3E,8'h46,8'h1C,8'h32,8'h21,8'h23,8'h24,8'h2B};

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // memory model and event recorders
  logic [7:0] mem [int unsigned];
  logic [7:0] shadow [int unsigned];
  int unsigned cyc = 0, key_cyc = 0, wr_cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, en_cnt = 0;
  logic [15:0] last_wa = '0, last_ra = '0;
  logic [7:0]  last_wd = '0;

  function automatic logic [7:0] mdef(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (kb_valid) key_cyc <= cyc;
    if (cpu_clk_en) en_cnt <= en_cnt + 1;
    if (mem_wr) begin
      mem[mem_addr] = mem_wdata;
      wr_cnt <= wr_cnt + 1; wr_cyc <= cyc; last_wa <= mem_addr; last_wd <= mem_wdata;
    end
    if (mem_rd) begin
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : mdef(mem_addr);
      rd_cnt <= rd_cnt + 1; last_ra <= mem_addr;
    end
  end

  logic [15:0] e_addr = '0;
  logic [7:0]  e_data = '0;
  bit          e_hi = 1;

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    return shadow.exists(a) ? shadow[a] : mdef(a);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); kb_code = c; kb_valid = 1'b1;
    @(negedge clk); kb_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_disp(input string tag);
    chk(tag, {8'h0, disp_hex}, {8'h0, e_addr, e_data});
  endtask

  task automatic hex_key(input int n);
    send(HEXC[n]);
    e_data = e_hi ? {n[3:0], e_data[3:0]} : {e_data[7:4], n[3:0]};
    e_hi = !e_hi;
    chk_disp("R7 nibble entry");
  endtask

  task automatic enter_key();
    int w0;
    w0 = wr_cnt;
    send(8'h5A);
    chk("R5 one write", wr_cnt, w0 + 1);
    chk("R5 write addr", last_wa, e_addr);
    chk("R5 write data", last_wd, e_data);
    chk("R5 write timing", wr_cyc - key_cyc, 2);
    shadow[e_addr] = e_data;
    e_addr = e_addr + 16'd1;
    e_data = exp_rd(e_addr);
    e_hi = 1;
    chk("R5 read addr", last_ra, e_addr);
    chk_disp("R5 display after enter");
  endtask

  task automatic back_key();
    int w0;
    w0 = wr_cnt;
    send(8'h66);
    e_addr = e_addr - 16'd1;
    e_data = exp_rd(e_addr);
    chk("R6 no write", wr_cnt, w0);
    chk_disp("R6 display after backspace");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w0, r0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 display", disp_hex, 24'h0);
    chk("R1 dp", disp_dp, 6'h3F);
    chk("R1 cpu_reset", cpu_reset, 1);
    chk("R1 clk_en", cpu_clk_en, 0);
    chk("R1 strobes", {mem_rd, mem_wr}, 0);

    // R7 sweep of all hex digits in both nibble positions
    for (int i = 0; i < 16; i++) begin
      hex_key(i);
      hex_key(15 - i);
    end
    hex_key(3);

    // R5 deposit sweep with auto-advance, then R6 walk back
    send(8'h29); e_addr = 0; chk_disp("R4 clear before sweep");
    enter_key();
    for (int i = 0; i < 16; i++) begin
      hex_key(i);
      hex_key(i ^ 5);
      enter_key();
    end
    for (int i = 0; i < 17; i++) back_key();

    // R9 wrap both ways
    chk("R9 at zero", e_addr, 0);
    back_key();
    chk("R9 wrap down", disp_hex[23:8], 16'hFFFF);
    hex_key(7); hex_key(12);
    enter_key();
    chk("R9 wrap up", disp_hex[23:8], 16'h0000);

    // R4 space clears address only
    enter_key(); enter_key();
    w0 = wr_cnt; r0 = rd_cnt;
    send(8'h29);
    e_addr = 0;
    chk_disp("R4 space clears address, keeps data");
    chk("R4 no strobe", wr_cnt + rd_cnt, w0 + r0);

    // R8 hex, S, R leave address; R10 no clock in entry
    e0 = en_cnt;
    enter_key();
    hex_key(9);
    send(8'h1B); send(8'h2D);
    chk_disp("R8 address unchanged by non-address keys");
    chk("R10 no clk_en in entry", en_cnt, e0);

    // R11 break prefix, extended prefix, repeated make
    w0 = wr_cnt;
    send(8'hF0); send(8'h5A);
    chk("R11 break drops byte", wr_cnt, w0);
    chk_disp("R11 break leaves display");
    send(8'hE0);
    enter_key();
    enter_key(); enter_key();

    // R12 key right behind Enter is ignored
    @(negedge clk); kb_code = 8'h5A; kb_valid = 1'b1;
    @(negedge clk); kb_code = HEXC[1];
    @(negedge clk); kb_valid = 1'b0;
    repeat (8) @(negedge clk);
    shadow[e_addr] = e_data;
    e_addr = e_addr + 16'd1; e_data = exp_rd(e_addr); e_hi = 1;
    chk_disp("R12 key during sequence ignored");

    // R2 / R3 / R10 run mode
    send(8'h76);
    chk("R2 run reset low", cpu_reset, 0);
    chk("R2 run dp dark", disp_dp, 0);
    chk("R3 run display", disp_hex, {cpu_addr, cpu_data});
    cpu_addr = 16'h1234; cpu_data = 8'hA5; #1;
    chk("R3 run display follows bus", disp_hex, 24'h1234A5);
    e0 = en_cnt; send(8'h1B);
    chk("R10 single step", en_cnt - e0, 1);
    e0 = en_cnt; send(8'h1B);
    chk("R10 second step", en_cnt - e0, 1);
    send(8'h2D);
    e0 = en_cnt; repeat (20) @(negedge clk);
    chk("R10 continuous run", en_cnt - e0, 20);
    send(8'h1B);
    e0 = en_cnt; repeat (10) @(negedge clk);
    chk("R10 S ignored while running", en_cnt - e0, 10);
    w0 = wr_cnt; r0 = rd_cnt;
    send(8'h5A); send(8'h66); send(8'h29); send(HEXC[4]);
    chk("R12 entry keys ignored in run", wr_cnt + rd_cnt, w0 + r0);
    send(8'h2D);
    e0 = en_cnt; repeat (10) @(negedge clk);
    chk("R10 second R stops", en_cnt - e0, 0);
    send(8'h2D);
    send(8'h76);
    chk("R2 back to entry reset", cpu_reset, 1);
    chk("R2 entry dp lit", disp_dp, 6'h3F);
    chk_disp("R12 fields unchanged by run-mode keys");
    e0 = en_cnt; repeat (5) @(negedge clk);
    chk("R10 entry stops run", en_cnt - e0, 0);
    send(8'h76);
    e0 = en_cnt; repeat (5) @(negedge clk);
    chk("R10 stopped after re-entering run", en_cnt - e0, 0);
    send(8'h76);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule